// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block receives words over a three-wire serial link (serial clock, serial data, load strobe) and steers each completed word into one of four parallel holding registers. All three serial pins are brought into the system clock domain through synchronisers. Edges of the serial clock and of the load strobe are then detected with the system clock. Each rising serial-clock edge shifts one data bit into a 24-bit shift path, most significant bit first.

When the load strobe rises, the block checks how many bits arrived since the previous strobe. If exactly 24 bits arrived, the whole word is copied into the register chosen by its two lowest bits, and that register's update pulse fires for one system cycle. If any other number of bits arrived, the word is dropped and a sticky framing-error flag is raised. In both cases the bit count restarts, so the next word begins from a clean state.

Downstream logic reads the four registers as parallel outputs. It can use the update pulses to act on fresh values. The meaning of the fields inside each register is left to that logic.

Top module: `ser3w_reg_loader`

## Requirements
- R1: After reset every holding register reads zero, no update pulse is high and the framing-error flag is low.
- R2: Data is taken on rising serial-clock edges only, and the first bit shifted in becomes bit 23 of the stored word.
- R3: A valid word is written into register k, where k is the value of word bits [1:0] (0 to 3). Register k appears on `lat_o[k*24 +: 24]`, and the other registers keep their contents.
- R4: The registers change only on a rising load-strobe edge. Shifting bits without a strobe changes nothing, and holding the strobe high causes no second write.
- R5: Each valid load raises exactly one bit of `upd_o` (the bit of the written register) for exactly one system cycle.
- R6: A strobe after a bit count other than 24 (fewer, more, or none) writes no register, raises no update pulse and sets `frame_err_o`.
- R7: `frame_err_o` stays high once set, including across later valid loads, until reset.
- R8: The bit count restarts at every strobe, valid or not, so a correct 24-bit word sent after a malformed one is loaded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; data sampled on its rising edge |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| ser_ld_i | input | 1 | Load strobe; rising edge commits the shifted word |
| lat_o | output | 96 | Four 24-bit holding registers, register k at bits k*24 upward |
| upd_o | output | 4 | One-cycle write pulse per register |
| frame_err_o | output | 1 | Sticky flag: a strobe arrived after a wrong bit count |

## Verification
The bench builds the block with its default parameters: a 24-bit word, a 2-bit register address and two synchroniser stages. These settings make all four destination registers reachable, and they let a 25-bit frame and a zero-bit frame drive the counter past and below the valid count. With two-stage synchronisers, the serial pins held for four system cycles per phase exercise the edge detectors at close to their minimum margin.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;

    // Event view of one synchronised serial pin.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_ev_t;

    localparam int unsigned DEF_WORD_W = 24;
    localparam int unsigned DEF_ADDR_W = 2;
    localparam int unsigned DEF_SYNC_N = 2;

endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync
    import ser3w_pkg::*;
#(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = DEF_SYNC_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDTH-1:0]     pin_i,
    output pin_ev_t [WIDTH-1:0]  ev_o
);

    localparam int unsigned TOP = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        typedef struct packed {
            logic [STAGES-1:0] chain;
            logic              prev;
        } sync_st_t;

        sync_st_t st_d, st_q;

        always_comb begin
            st_d       = st_q;
            st_d.chain = {st_q.chain[STAGES-2:0], pin_i[g]};
            st_d.prev  = st_q.chain[TOP];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign ev_o[g].level = st_q.chain[TOP];
        assign ev_o[g].rise  = st_q.chain[TOP] & ~st_q.prev;
        assign ev_o[g].fall  = ~st_q.chain[TOP] & st_q.prev;
    end

endmodule

// File: rtl/ser3w_shifter.sv
module ser3w_shifter #(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    input  logic              commit_i,
    output logic [WORD_W-1:0] word_o,
    output logic              full_o
);

    localparam int unsigned CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            st_d.cnt = '0;
        end else if (shift_i) begin
            st_d.sr  = {st_q.sr[WORD_W-2:0], bit_i};
            st_d.cnt = (st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.sr;
    assign full_o = (st_q.cnt == CNT_GOOD);

endmodule

// File: rtl/ser3w_latch_bank.sv
module ser3w_latch_bank #(
    parameter int unsigned WORD_W = 24,
    parameter int unsigned ADDR_W = 2,
    localparam int unsigned NUM   = 2 ** ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_i,
    input  logic                  full_i,
    input  logic [WORD_W-1:0]     word_i,
    output logic [NUM*WORD_W-1:0] lat_o,
    output logic [NUM-1:0]        upd_o,
    output logic                  err_o
);

    typedef struct packed {
        logic [NUM-1:0][WORD_W-1:0] lat;
        logic [NUM-1:0]             pulse;
        logic                       err;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [ADDR_W-1:0] sel;

    assign sel = word_i[ADDR_W-1:0];

    always_comb begin
        st_d       = st_q;
        st_d.pulse = '0;
        if (commit_i) begin
            if (full_i) begin
                st_d.lat[sel]   = word_i;
                st_d.pulse[sel] = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM; g++) begin : g_out
        assign lat_o[g*WORD_W +: WORD_W] = st_q.lat[g];
    end

    assign upd_o = st_q.pulse;
    assign err_o = st_q.err;

endmodule

// File: rtl/ser3w_reg_loader.sv
module ser3w_reg_loader
    import ser3w_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned SYNC_N = DEF_SYNC_N,
    localparam int unsigned NUM   = 2 ** ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk_i,
    input  logic                  ser_dat_i,
    input  logic                  ser_ld_i,
    output logic [NUM*WORD_W-1:0] lat_o,
    output logic [NUM-1:0]        upd_o,
    output logic                  frame_err_o
);

    localparam int unsigned P_CLK = 0;
    localparam int unsigned P_DAT = 1;
    localparam int unsigned P_LD  = 2;

    pin_ev_t [2:0]     ev;
    logic [WORD_W-1:0] word;
    logic              full;

    ser3w_sync #(.WIDTH(3), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({ser_ld_i, ser_dat_i, ser_clk_i}),
        .ev_o  (ev)
    );

    ser3w_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (ev[P_CLK].rise),
        .bit_i    (ev[P_DAT].level),
        .commit_i (ev[P_LD].rise),
        .word_o   (word),
        .full_o   (full)
    );

    ser3w_latch_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (ev[P_LD].rise),
        .full_i   (full),
        .word_i   (word),
        .lat_o    (lat_o),
        .upd_o    (upd_o),
        .err_o    (frame_err_o)
    );

endmodule

// File: rtl/ser3w_loader_chk.sv
module ser3w_loader_chk #(
    parameter int unsigned WORD_W = 24,
    parameter int unsigned ADDR_W = 2,
    localparam int unsigned NUM   = 2 ** ADDR_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM*WORD_W-1:0] lat_o,
    input logic [NUM-1:0]        upd_o,
    input logic                  frame_err_o
);

    assert_pulse_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_o));

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_o) |=> !(|upd_o));

    assert_quiet_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o == '0) |-> $stable(lat_o));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> frame_err_o);

    assert_err_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err_o) |-> (upd_o == '0));

endmodule

bind ser3w_reg_loader ser3w_loader_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lat_o       (lat_o),
    .upd_o       (upd_o),
    .frame_err_o (frame_err_o)
);

// File: tb/ser3w_reg_loader_bench.sv
`timescale 1ns/1ps
module ser3w_reg_loader_bench;

    localparam int W = 24;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
    logic [N*W-1:0] lat;
    logic [N-1:0]   upd;
    logic           ferr;

    int n_chk = 0, n_bad = 0;
    int pcnt [N];
    logic [W-1:0] model [N];
    bit done = 1'b0;

    localparam logic [W-1:0] VEC [8] = '{
        24'h123450, 24'h89ABC1, 24'hFEDCB2, 24'h000003,
        24'hFFFFFF, 24'h800001, 24'h55AA56, 24'h7E8180
    };

    always #2.5 clk = ~clk;

    ser3w_reg_loader u_ser3w_reg_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .ser_ld_i(ser_ld), .lat_o(lat), .upd_o(upd), .frame_err_o(ferr)
    );

    always @(negedge clk)
        if (rst_n)
            for (int k = 0; k < N; k++) if (upd[k]) pcnt[k]++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); ser_dat = v[i];
            repeat (4) @(negedge clk); ser_clk = 1'b1;
            repeat (4) @(negedge clk); ser_clk = 1'b0;
        end
    endtask

    task automatic strobe(input int hold);
        repeat (4) @(negedge clk); ser_ld = 1'b1;
        repeat (hold) @(negedge clk); ser_ld = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic check_regs(input string tag);
        for (int k = 0; k < N; k++)
            chk(lat[k*W +: W] == model[k], tag, 32'(lat[k*W +: W]), 32'(model[k]));
    endtask

    task automatic check_pulses(input string tag, input int exp [N]);
        for (int k = 0; k < N; k++)
            chk(pcnt[k] == exp[k], tag, 32'(pcnt[k]), 32'(exp[k]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int ep [N];
        for (int k = 0; k < N; k++) begin pcnt[k] = 0; model[k] = '0; ep[k] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        check_regs("R1 reset registers");
        chk(upd == '0, "R1 reset pulses", 32'(upd), 0);
        chk(ferr == 1'b0, "R1 reset error", 32'(ferr), 0);

        // R2 R3 R5: table of valid words over all addresses
        foreach (VEC[i]) begin
            send_bits(32'(VEC[i]), W);
            strobe(4);
            model[VEC[i][1:0]] = VEC[i];
            ep[VEC[i][1:0]]++;
            check_regs("R2 R3 table word");
            check_pulses("R5 table pulses", ep);
            chk(ferr == 1'b0, "R6 no error on valid", 32'(ferr), 0);
        end

        // R4: bits shifted without a strobe leave registers untouched
        send_bits(32'h00DEAD01, W);
        repeat (10) @(negedge clk);
        check_regs("R4 no strobe no write");
        check_pulses("R4 no strobe no pulse", ep);
        // R4 R5: long strobe writes once
        strobe(30);
        model[1] = 24'hDEAD01; ep[1]++;
        check_regs("R4 long strobe write");
        check_pulses("R5 long strobe single pulse", ep);

        // R6: 23 bits
        send_bits(32'h00ABCDE2, W - 1);
        strobe(4);
        check_regs("R6 short frame dropped");
        check_pulses("R6 short frame no pulse", ep);
        chk(ferr == 1'b1, "R6 short frame error", 32'(ferr), 1);

        // R8 R7: valid word after malformed one
        send_bits(32'h0013579B, W);
        strobe(4);
        model[3] = 24'h13579B; ep[3]++;
        check_regs("R8 recovery load");
        check_pulses("R8 recovery pulse", ep);
        chk(ferr == 1'b1, "R7 error sticky", 32'(ferr), 1);

        // R6: 25 bits
        send_bits({7'd0, 1'b1, 24'h2468AE}, W + 1);
        strobe(4);
        check_regs("R6 long frame dropped");
        check_pulses("R6 long frame no pulse", ep);

        // R6: strobe with no bits
        strobe(4);
        check_regs("R6 empty frame dropped");
        check_pulses("R6 empty frame no pulse", ep);
        chk(ferr == 1'b1, "R7 error still set", 32'(ferr), 1);

        // R1 R7: reset clears everything
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < N; k++) model[k] = '0;
        check_regs("R1 re-reset registers");
        chk(ferr == 1'b0, "R7 reset clears error", 32'(ferr), 0);

        // R2: MSB-first after reset
        send_bits(32'h00C00002, W);
        strobe(4);
        model[2] = 24'hC00002;
        check_regs("R2 msb first");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule